// File: doc/BRIEF.md
# Multi-Mode Control Register Bank

This block is a slave register bank reached over a 32-bit AXI4-Lite port. It holds a fixed set of registers, one per 4-byte word. Each register is given an access mode by parameter, and that mode decides how software and the hardware side may change the register and what a software read returns. The modes are:

- hardware-loaded read-only
- read-only cleared by a read
- write-only
- write-only with a one-cycle event pulse
- software-only read/write
- shared hardware/software read/write
- read/write cleared by a read
- read/write cleared by any write

Each register also has a byte width, a reset default and a byte order, all set by parameter. All hardware-side ports share the bus clock. No synchronizer stages are included.

The default configuration has eight registers, one per mode, and the register index equals the mode code. Register 0 and register 4 are big-endian. Offsets 0x20 to 0x3C are unmapped.

Top module: `ctl_reg_bank`

## Requirements
- R1: After reset every register holds its own default, masked to its width. Defaults by index 0..7: 0x11223344, 0x00A5, 0x5A, 0, 0xCAFE0001, 0x123456, 0x10, 0xFFFF0000. The hardware-side output `regOut[i]` shows the stored value.
- R2: Write address and write data are accepted in either order. `bValid` rises only once both have been accepted, and a read returns `rValid` in the cycle after the address handshake. Both `bResp` and `rResp` are 2'b00 (OKAY).
- R3: Register widths in bytes by index 0..7 are 4, 2, 1, 4, 4, 3, 4, 4. Bits above a register's width are stored as zero and read as zero.
- R4: Software writes to mode 0 (read-only) and mode 1 (read-only, cleared by a read) have no effect. Both modes load `hwData` whenever `hwWe` is high.
- R5: Modes 1 and 6 become zero right after the read-data handshake edge (`rValid` and `rReady` both high). If `hwWe` is high on that same edge, the hardware value is kept instead of the zero.
- R6: Mode 2 (write-only) and mode 3 (event) read as zero. Their written value appears on `regOut`.
- R7: A completed write to a mode-3 register raises its `regEvt` bit for exactly one cycle: the cycle in which `bValid` is first high. All other `regEvt` bits stay low.
- R8: In mode 5, a software write that commits on the same edge as `hwWe` wins. On any other edge, `hwWe` loads `hwData`.
- R9: In mode 7, any software write clears the register to zero whatever its data. `hwWe` loads `hwData`, and a read does not clear it.
- R10: Big-endian registers reverse their byte lanes on both reads and writes. Bus byte k maps to stored byte 3-k.
- R11: An access to an unmapped offset completes with OKAY, changes no register, and reads as zero.
- R12: A write changes only the bus byte lanes whose `wStrb` bit is set. Lane k is `wData[8k+7:8k]`. For a big-endian register, lanes are taken in bus order before the reversal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rstN | input | 1 | Active-low synchronous reset |
| awValid | input | 1 | Write address valid |
| awReady | output | 1 | Write address ready |
| awAddr | input | ADDR_W | Write byte address |
| wValid | input | 1 | Write data valid |
| wReady | output | 1 | Write data ready |
| wData | input | 32 | Write data |
| wStrb | input | 4 | Write byte strobes |
| bValid | output | 1 | Write response valid |
| bReady | input | 1 | Write response ready |
| bResp | output | 2 | Write response, always OKAY |
| arValid | input | 1 | Read address valid |
| arReady | output | 1 | Read address ready |
| arAddr | input | ADDR_W | Read byte address |
| rValid | output | 1 | Read data valid |
| rReady | input | 1 | Read data ready |
| rData | output | 32 | Read data |
| rResp | output | 2 | Read response, always OKAY |
| hwWe | input | NUM_REGS | Per-register hardware load enable |
| hwData | input | NUM_REGS x 32 | Per-register hardware load value |
| regOut | output | NUM_REGS x 32 | Per-register stored value, hardware byte order |
| regEvt | output | NUM_REGS | One-cycle write event per register |

## Verification
Two pairs of functions can land on the same clock edge.

- **Shared register:** a software write and a hardware load can meet in the shared read/write register.
- **Clear-on-read registers:** the clear after a read handshake can meet a hardware load.

The bench provokes each collision by raising `hwWe` in the exact cycle before the write-commit edge or the read-handshake edge. Random traffic adds further coincidences. The bench judges the surviving value on `regOut` and by a later read against a model that applies the stated priority: software write first, then hardware load, then clear.

// File: rtl/ctl_reg_pkg.sv
package ctl_reg_pkg;
  localparam int BUS_W = 32;
  localparam int LANES = BUS_W / 8;

  typedef enum logic [2:0] {
    MODE_RO   = 3'd0,
    MODE_ROC  = 3'd1,
    MODE_WO   = 3'd2,
    MODE_WOE  = 3'd3,
    MODE_RWS  = 3'd4,
    MODE_RWA  = 3'd5,
    MODE_RWCR = 3'd6,
    MODE_RWCW = 3'd7
  } regMode_e;

  // Strobes from the bus control to the register datapath.
  typedef struct packed {
    logic             wrEn;
    logic             rdClr;
    logic [BUS_W-1:0] wrData;
    logic [LANES-1:0] wrStrb;
  } busStrobe_t;

  function automatic logic [BUS_W-1:0] laneSwap(input logic [BUS_W-1:0] d);
    logic [BUS_W-1:0] r;
    for (int k = 0; k < LANES; k++) r[8*k +: 8] = d[8*(LANES-1-k) +: 8];
    return r;
  endfunction

  function automatic logic [BUS_W-1:0] byteMask(input int nBytes);
    logic [BUS_W-1:0] m;
    m = '0;
    for (int k = 0; k < LANES; k++) if (k < nBytes) m[8*k +: 8] = 8'hFF;
    return m;
  endfunction

  function automatic logic [BUS_W-1:0] laneMerge(input logic [BUS_W-1:0] cur,
                                                 input logic [BUS_W-1:0] d,
                                                 input logic [LANES-1:0] s);
    logic [BUS_W-1:0] r;
    r = cur;
    for (int k = 0; k < LANES; k++) if (s[k]) r[8*k +: 8] = d[8*k +: 8];
    return r;
  endfunction
endpackage

// File: rtl/ctl_reg_ctrl.sv
module ctl_reg_ctrl
  import ctl_reg_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int ADDR_W   = 6
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             awValid,
  output logic                             awReady,
  input  logic [ADDR_W-1:0]                awAddr,
  input  logic                             wValid,
  output logic                             wReady,
  input  logic [BUS_W-1:0]                 wData,
  input  logic [LANES-1:0]                 wStrb,
  output logic                             bValid,
  input  logic                             bReady,
  output logic [1:0]                       bResp,
  input  logic                             arValid,
  output logic                             arReady,
  input  logic [ADDR_W-1:0]                arAddr,
  output logic                             rValid,
  input  logic                             rReady,
  output logic [BUS_W-1:0]                 rData,
  output logic [1:0]                       rResp,
  input  logic [NUM_REGS-1:0][BUS_W-1:0]   rdView,
  output busStrobe_t                       strb,
  output logic [NUM_REGS-1:0]              wrSel,
  output logic [NUM_REGS-1:0]              rdSel
);
  localparam int IDX_W = ADDR_W - 2;

  logic              awHeld, wHeld, bValidQ, rValidQ;
  logic [IDX_W-1:0]  wrIdxQ;
  logic [BUS_W-1:0]  wDataQ, rDataQ, rdMux;
  logic [LANES-1:0]  wStrbQ;
  logic [NUM_REGS-1:0] rdSelQ, arSel;
  logic              doWrite;
  logic              unusedAddrBits;

  assign unusedAddrBits = ^{awAddr[1:0], arAddr[1:0]};

  assign awReady = !awHeld && !bValidQ;
  assign wReady  = !wHeld && !bValidQ;
  assign arReady = !rValidQ;
  assign doWrite = awHeld && wHeld && !bValidQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      awHeld  <= 1'b0;
      wHeld   <= 1'b0;
      bValidQ <= 1'b0;
      wrIdxQ  <= '0;
      wDataQ  <= '0;
      wStrbQ  <= '0;
    end else begin
      if (awValid && awReady) begin
        awHeld <= 1'b1;
        wrIdxQ <= awAddr[ADDR_W-1:2];
      end
      if (wValid && wReady) begin
        wHeld  <= 1'b1;
        wDataQ <= wData;
        wStrbQ <= wStrb;
      end
      if (doWrite) begin
        awHeld  <= 1'b0;
        wHeld   <= 1'b0;
        bValidQ <= 1'b1;
      end else if (bValidQ && bReady) begin
        bValidQ <= 1'b0;
      end
    end
  end

  always_comb begin
    rdMux = '0;
    arSel = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (arAddr[ADDR_W-1:2] == IDX_W'(i)) begin
        rdMux    = rdView[i];
        arSel[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rValidQ <= 1'b0;
      rDataQ  <= '0;
      rdSelQ  <= '0;
    end else if (arValid && arReady) begin
      rValidQ <= 1'b1;
      rDataQ  <= rdMux;
      rdSelQ  <= arSel;
    end else if (rValidQ && rReady) begin
      rValidQ <= 1'b0;
    end
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
    assign wrSel[i] = (wrIdxQ == IDX_W'(i));
  end

  assign strb.wrEn   = doWrite;
  assign strb.wrData = wDataQ;
  assign strb.wrStrb = wStrbQ;
  assign strb.rdClr  = rValidQ && rReady;
  assign rdSel  = rdSelQ;
  assign bValid = bValidQ;
  assign rValid = rValidQ;
  assign rData  = rDataQ;
  assign bResp  = 2'b00;
  assign rResp  = 2'b00;
endmodule

// File: rtl/ctl_reg_dpath.sv
module ctl_reg_dpath
  import ctl_reg_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter logic [NUM_REGS-1:0][2:0]       REG_MODE   = '0,
  parameter logic [NUM_REGS-1:0][2:0]       REG_BYTES  = '0,
  parameter logic [NUM_REGS-1:0][BUS_W-1:0] REG_RESET  = '0,
  parameter logic [NUM_REGS-1:0]            REG_BIGEND = '0
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  busStrobe_t                     strb,
  input  logic [NUM_REGS-1:0]            wrSel,
  input  logic [NUM_REGS-1:0]            rdSel,
  input  logic [NUM_REGS-1:0]            hwWe,
  input  logic [NUM_REGS-1:0][BUS_W-1:0] hwData,
  output logic [NUM_REGS-1:0][BUS_W-1:0] regOut,
  output logic [NUM_REGS-1:0]            regEvt,
  output logic [NUM_REGS-1:0][BUS_W-1:0] rdView
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [BUS_W-1:0] MASK = byteMask(int'(REG_BYTES[i]));
    localparam bit               BIG  = REG_BIGEND[i];
    localparam regMode_e         MODE = regMode_e'(REG_MODE[i]);

    logic [BUS_W-1:0] val, nxt, busCur, merged, swVal, hwVal;
    logic swWr, rdClr, evtQ;

    assign swWr   = strb.wrEn && wrSel[i];
    assign rdClr  = strb.rdClr && rdSel[i];
    assign busCur = BIG ? laneSwap(val) : val;
    assign merged = laneMerge(busCur, strb.wrData, strb.wrStrb);
    assign swVal  = (BIG ? laneSwap(merged) : merged) & MASK;
    assign hwVal  = hwData[i] & MASK;

    // Priority where modes allow several sources: software write, hardware load, clear.
    always_comb begin
      nxt = val;
      case (MODE)
        MODE_RO:   if (hwWe[i]) nxt = hwVal;
        MODE_ROC:  if (hwWe[i]) nxt = hwVal; else if (rdClr) nxt = '0;
        MODE_WO, MODE_WOE, MODE_RWS:
                   if (swWr) nxt = swVal;
        MODE_RWA:  if (swWr) nxt = swVal; else if (hwWe[i]) nxt = hwVal;
        MODE_RWCR: if (swWr) nxt = swVal; else if (hwWe[i]) nxt = hwVal;
                   else if (rdClr) nxt = '0;
        MODE_RWCW: if (swWr) nxt = '0; else if (hwWe[i]) nxt = hwVal;
        default:   nxt = val;
      endcase
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        val  <= REG_RESET[i] & MASK;
        evtQ <= 1'b0;
      end else begin
        val  <= nxt;
        evtQ <= swWr && (MODE == MODE_WOE);
      end
    end

    assign regOut[i] = val;
    assign regEvt[i] = evtQ;
    assign rdView[i] = (MODE == MODE_WO || MODE == MODE_WOE) ? '0 : busCur;
  end
endmodule

// File: rtl/ctl_reg_bank.sv
module ctl_reg_bank
  import ctl_reg_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int ADDR_W   = 6,
  parameter logic [NUM_REGS-1:0][2:0] REG_MODE =
    {3'd7, 3'd6, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0},
  parameter logic [NUM_REGS-1:0][2:0] REG_BYTES =
    {3'd4, 3'd4, 3'd3, 3'd4, 3'd4, 3'd1, 3'd2, 3'd4},
  parameter logic [NUM_REGS-1:0][31:0] REG_RESET =
    {32'hFFFF_0000, 32'h0000_0010, 32'h0012_3456, 32'hCAFE_0001,
     32'h0000_0000, 32'h0000_005A, 32'h0000_00A5, 32'h1122_3344},
  parameter logic [NUM_REGS-1:0] REG_BIGEND = 8'b0001_0001
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        awValid,
  output logic                        awReady,
  input  logic [ADDR_W-1:0]           awAddr,
  input  logic                        wValid,
  output logic                        wReady,
  input  logic [31:0]                 wData,
  input  logic [3:0]                  wStrb,
  output logic                        bValid,
  input  logic                        bReady,
  output logic [1:0]                  bResp,
  input  logic                        arValid,
  output logic                        arReady,
  input  logic [ADDR_W-1:0]           arAddr,
  output logic                        rValid,
  input  logic                        rReady,
  output logic [31:0]                 rData,
  output logic [1:0]                  rResp,
  input  logic [NUM_REGS-1:0]         hwWe,
  input  logic [NUM_REGS-1:0][31:0]   hwData,
  output logic [NUM_REGS-1:0][31:0]   regOut,
  output logic [NUM_REGS-1:0]         regEvt
);
  busStrobe_t                      strb;
  logic [NUM_REGS-1:0]             wrSel, rdSel;
  logic [NUM_REGS-1:0][BUS_W-1:0]  rdView;

  ctl_reg_ctrl #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .awValid(awValid), .awReady(awReady), .awAddr(awAddr),
    .wValid(wValid), .wReady(wReady), .wData(wData), .wStrb(wStrb),
    .bValid(bValid), .bReady(bReady), .bResp(bResp),
    .arValid(arValid), .arReady(arReady), .arAddr(arAddr),
    .rValid(rValid), .rReady(rReady), .rData(rData), .rResp(rResp),
    .rdView(rdView), .strb(strb), .wrSel(wrSel), .rdSel(rdSel)
  );

  ctl_reg_dpath #(
    .NUM_REGS(NUM_REGS), .REG_MODE(REG_MODE), .REG_BYTES(REG_BYTES),
    .REG_RESET(REG_RESET), .REG_BIGEND(REG_BIGEND)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .wrSel(wrSel), .rdSel(rdSel),
    .hwWe(hwWe), .hwData(hwData), .regOut(regOut), .regEvt(regEvt),
    .rdView(rdView)
  );
endmodule

// File: rtl/ctl_reg_bank_chk.sv
module ctl_reg_bank_chk
  import ctl_reg_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter logic [NUM_REGS-1:0][2:0] REG_MODE  = '0,
  parameter logic [NUM_REGS-1:0][2:0] REG_BYTES = '0
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        bValid,
  input logic                        bReady,
  input logic                        rValid,
  input logic                        rReady,
  input logic [31:0]                 rData,
  input logic [NUM_REGS-1:0]         hwWe,
  input logic [NUM_REGS-1:0][31:0]   hwData,
  input logic [NUM_REGS-1:0][31:0]   regOut,
  input logic [NUM_REGS-1:0]         regEvt
);
  a_r2_bvalid_hold: assert property (@(posedge clk) disable iff (!rstN)
    bValid && !bReady |=> bValid);

  a_r2_rvalid_hold: assert property (@(posedge clk) disable iff (!rstN)
    rValid && !rReady |=> rValid && $stable(rData));

  a_r7_event_single: assert property (@(posedge clk) disable iff (!rstN)
    (regEvt != '0) |=> ((regEvt & $past(regEvt)) == '0));

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_chk
    localparam logic [31:0] MASK = byteMask(int'(REG_BYTES[i]));

    a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
      (regOut[i] & ~MASK) == '0);

    if (REG_MODE[i] == MODE_RO) begin : g_ro
      a_r4_ro_hold: assert property (@(posedge clk) disable iff (!rstN)
        !hwWe[i] |=> $stable(regOut[i]));
    end

    if (REG_MODE[i] == MODE_RWA) begin : g_rwa
      // R8: hardware load lands unless a software write committed on that edge
      a_r8_rwa_hw_load: assert property (@(posedge clk) disable iff (!rstN)
        hwWe[i] |=> (regOut[i] == ($past(hwData[i]) & MASK)) || $rose(bValid));
    end
  end
endmodule

bind ctl_reg_bank ctl_reg_bank_chk #(
  .NUM_REGS(NUM_REGS), .REG_MODE(REG_MODE), .REG_BYTES(REG_BYTES)
) u_chk (
  .clk(clk), .rstN(rstN), .bValid(bValid), .bReady(bReady),
  .rValid(rValid), .rReady(rReady), .rData(rData),
  .hwWe(hwWe), .hwData(hwData), .regOut(regOut), .regEvt(regEvt)
);

// File: tb/ctl_reg_bank_tb.sv
module ctl_reg_bank_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, awValid, awReady, wValid, wReady, bValid, bReady;
  logic arValid, arReady, rValid, rReady;
  logic [5:0] awAddr, arAddr;
  logic [31:0] wData, rData;
  logic [3:0] wStrb;
  logic [1:0] bResp, rResp;
  logic [7:0] hwWe, regEvt;
  logic [7:0][31:0] hwData, regOut;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;
  logic [31:0] model [8];

  ctl_reg_bank u_dut (
    .clk(clk), .rstN(rstN), .awValid(awValid), .awReady(awReady), .awAddr(awAddr),
    .wValid(wValid), .wReady(wReady), .wData(wData), .wStrb(wStrb),
    .bValid(bValid), .bReady(bReady), .bResp(bResp),
    .arValid(arValid), .arReady(arReady), .arAddr(arAddr),
    .rValid(rValid), .rReady(rReady), .rData(rData), .rResp(rResp),
    .hwWe(hwWe), .hwData(hwData), .regOut(regOut), .regEvt(regEvt)
  );

  // Index equals mode: 0 RO, 1 ROC, 2 WO, 3 WOE, 4 RWS, 5 RWA, 6 RWCR, 7 RWCW
  function automatic logic [31:0] swapB(input logic [31:0] d);
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction
  function automatic int nBytes(input int i);
    case (i) 1: return 2; 2: return 1; 5: return 3; default: return 4; endcase
  endfunction
  function automatic logic [31:0] maskOf(input int i);
    logic [31:0] m = '0;
    for (int k = 0; k < nBytes(i); k++) m[8*k +: 8] = 8'hFF;
    return m;
  endfunction
  function automatic logic [31:0] rstOf(input int i);
    case (i)
      0: return 32'h1122_3344; 1: return 32'h0000_00A5; 2: return 32'h0000_005A;
      3: return 32'h0;         4: return 32'hCAFE_0001; 5: return 32'h0012_3456;
      6: return 32'h0000_0010; default: return 32'hFFFF_0000;
    endcase
  endfunction
  function automatic bit isBig(input int i);
    return (i == 0) || (i == 4);
  endfunction
  function automatic logic [31:0] expRead(input int i);
    if (i > 7 || i == 2 || i == 3) return 32'h0;
    return isBig(i) ? swapB(model[i]) : model[i];
  endfunction

  task automatic hwApply(input int i, input logic [31:0] v);
    if (i == 0 || i == 1 || i == 5 || i == 6 || i == 7) model[i] = v & maskOf(i);
  endtask
  task automatic swApply(input int i, input logic [31:0] d, input logic [3:0] s);
    logic [31:0] cur;
    if (i > 7 || i < 2) return;
    if (i == 7) begin model[i] = 32'h0; return; end
    cur = isBig(i) ? swapB(model[i]) : model[i];
    for (int k = 0; k < 4; k++) if (s[k]) cur[8*k +: 8] = d[8*k +: 8];
    model[i] = (isBig(i) ? swapB(cur) : cur) & maskOf(i);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic checkOuts(input string tag);
    for (int i = 0; i < 8; i++) chk(tag, regOut[i], model[i]);
  endtask

  // order 0: address and data together, 1: address first, 2: data first
  task automatic axiWrite(input int idx, input logic [31:0] d, input logic [3:0] s,
                          input int order, input bit hit, input logic [31:0] hv);
    @(negedge clk);
    awAddr = 6'(idx * 4); wData = d; wStrb = s;
    if (order == 0) begin
      awValid = 1; wValid = 1;
      @(negedge clk); awValid = 0; wValid = 0;
    end else begin
      if (order == 1) awValid = 1; else wValid = 1;
      @(negedge clk); awValid = 0; wValid = 0;
      repeat (2) @(negedge clk);
      chk("R2", {31'b0, bValid}, 32'h0);
      if (order == 1) wValid = 1; else awValid = 1;
      @(negedge clk); awValid = 0; wValid = 0;
    end
    if (hit && idx < 8) begin
      hwWe[idx] = 1'b1; hwData[idx] = hv; hwApply(idx, hv);
    end
    swApply(idx, d, s);
    @(negedge clk);
    hwWe = '0;
    chk("R2", {31'b0, bValid}, 32'h1);
    chk("R2", {30'b0, bResp}, 32'h0);
    chk("R7", {24'b0, regEvt}, (idx == 3) ? 32'h08 : 32'h0);
    @(negedge clk);
    chk("R7", {24'b0, regEvt}, 32'h0);
    chk("R2", {31'b0, bValid}, 32'h0);
  endtask

  task automatic axiRead(input int idx, input bit hit, input logic [31:0] hv,
                         input string tag);
    logic [31:0] exp;
    exp = expRead(idx);
    @(negedge clk);
    arAddr = 6'(idx * 4); arValid = 1;
    @(negedge clk);
    arValid = 0;
    chk("R2", {31'b0, rValid}, 32'h1);
    chk("R2", {30'b0, rResp}, 32'h0);
    chk(tag, rData, exp);
    if (idx == 1 || idx == 6) model[idx] = 32'h0;
    if (hit && idx < 8) begin
      hwWe[idx] = 1'b1; hwData[idx] = hv; hwApply(idx, hv);
    end
    @(negedge clk);
    hwWe = '0;
    chk("R2", {31'b0, rValid}, 32'h0);
  endtask

  task automatic hwPulse(input int idx, input logic [31:0] v);
    @(negedge clk);
    hwWe[idx] = 1'b1; hwData[idx] = v; hwApply(idx, v);
    @(negedge clk);
    hwWe = '0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rv;
    rstN = 0; awValid = 0; wValid = 0; arValid = 0; bReady = 1; rReady = 1;
    awAddr = '0; arAddr = '0; wData = '0; wStrb = '0; hwWe = '0; hwData = '0;
    for (int i = 0; i < 8; i++) model[i] = rstOf(i) & maskOf(i);
    repeat (5) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    checkOuts("R1");
    for (int i = 0; i < 8; i++) axiRead(i, 0, 0, "R1");

    // R10 byte reversal on write and on read
    axiWrite(4, 32'h0102_0304, 4'hF, 0, 0, 0);
    chk("R10", regOut[4], 32'h0403_0201);
    axiRead(4, 0, 0, "R10");
    hwPulse(0, 32'hAABB_CCDD);
    axiRead(0, 0, 0, "R10");

    // R12 partial strobes, little and big endian
    axiWrite(5, 32'hA1B2_C3D4, 4'b0001, 0, 0, 0);
    chk("R12", regOut[5], 32'h0012_34D4);
    axiWrite(4, 32'h0000_00EE, 4'b0001, 0, 0, 0);
    chk("R12", regOut[4], 32'hEE03_0201);

    // R3 width mask, R6 write-only reads
    axiWrite(5, 32'hFFFF_FFFF, 4'hF, 0, 0, 0);
    axiRead(5, 0, 0, "R3");
    axiWrite(2, 32'hFFFF_FFFF, 4'hF, 0, 0, 0);
    chk("R6", regOut[2], 32'h0000_00FF);
    axiRead(2, 0, 0, "R6");

    // R4 read-only registers ignore software
    axiWrite(0, 32'h5555_5555, 4'hF, 0, 0, 0);
    axiWrite(1, 32'h5555_5555, 4'hF, 0, 0, 0);
    checkOuts("R4");
    axiRead(0, 0, 0, "R4");

    // R5 clear on read, with and without a coincident hardware load
    hwPulse(1, 32'h0000_1234);
    axiRead(1, 0, 0, "R5");
    axiRead(1, 0, 0, "R5");
    hwPulse(1, 32'h0000_0055);
    axiRead(1, 1, 32'h0000_0077, "R5");
    chk("R5", regOut[1], 32'h0000_0077);
    axiRead(1, 0, 0, "R5");
    axiWrite(6, 32'h0000_DEAD, 4'hF, 0, 0, 0);
    axiRead(6, 0, 0, "R5");
    axiRead(6, 0, 0, "R5");
    chk("R5", regOut[6], 32'h0);

    // R7 event pulse and R6 event register reads zero
    axiWrite(3, 32'h0000_CAFE, 4'hF, 0, 0, 0);
    chk("R7", regOut[3], 32'h0000_CAFE);
    axiRead(3, 0, 0, "R6");

    // R8 shared register priority
    hwPulse(5, 32'h00AB_CDEF);
    chk("R8", regOut[5], 32'h00AB_CDEF);
    axiWrite(5, 32'h0011_1111, 4'hF, 0, 1, 32'h0022_2222);
    chk("R8", regOut[5], 32'h0011_1111);

    // R9 clear on write
    hwPulse(7, 32'h0000_1357);
    axiRead(7, 0, 0, "R9");
    axiWrite(7, 32'hFFFF_FFFF, 4'hF, 0, 0, 0);
    chk("R9", regOut[7], 32'h0);
    axiRead(7, 0, 0, "R9");

    // R11 unmapped offsets
    axiRead(9, 0, 0, "R11");
    axiWrite(12, 32'h1234_5678, 4'hF, 0, 0, 0);
    checkOuts("R11");

    // R2 either channel order
    axiWrite(4, 32'h0BAD_F00D, 4'hF, 1, 0, 0);
    axiRead(4, 0, 0, "R2");
    axiWrite(4, 32'h600D_CAFE, 4'hF, 2, 0, 0);
    axiRead(4, 0, 0, "R2");

    // Random phase with a fixed seed
    rv = $urandom(32'h5EED);
    for (int n = 0; n < 400; n++) begin
      int op, idx;
      logic [3:0] s;
      op = int'($urandom_range(0, 2));
      idx = int'($urandom_range(0, 15));
      if (op == 0) begin
        s = 4'($urandom_range(1, 15));
        axiWrite(idx, $urandom, s, int'($urandom_range(0, 2)),
                 (s == 4'hF) && ($urandom_range(0, 3) == 0), $urandom);
      end else if (op == 1) begin
        axiRead(idx, (idx < 8) && ($urandom_range(0, 3) == 0), $urandom, "R3");
      end else begin
        hwPulse(idx % 8, $urandom);
      end
      checkOuts("R3");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule